// File: doc/BRIEF.md
# Built-in block observation register

This block is a multi-function register of configurable width that sits next to a combinational logic block, on its input side or on its output side. Two mode-control pins choose how the register behaves on each clock. In functional operation it is a plain parallel register. For test access it becomes one stage of a serial scan chain. It can be cleared synchronously. In self-test mode it runs a linear feedback shift register: with the parallel inputs held at zero it produces pseudo-random stimulus, and with changing parallel inputs it folds them into a running signature.

Placing one such register in front of a logic block and another behind it allows the block to be tested with no external pattern source and no external response checker. The upstream register generates the patterns. The downstream register compacts the responses, and its final value is then read out, for example by scanning.

Top module: `bilbo_reg`

## Requirements
- R1: The 2-bit mode code is {mode_c0, mode_c1}, with mode_c0 as the upper bit. Code 00 selects scan, 01 selects clear, 10 selects self-test and 11 selects normal load.
- R2: In scan mode, each rising clock edge shifts the register one place toward the most significant bit, and scan_in enters at bit 0.
- R3: In clear mode, a rising clock edge sets every register bit to zero.
- R4: In normal mode, a rising clock edge loads par_in into the register.
- R5: In self-test mode with par_in all zero and a nonzero register, the next state is {q[W-2:0], f}. The feedback bit f is the XOR of the tap bits; for the default width of 8 the taps are bits 7, 5, 4 and 3. From any nonzero seed, the sequence repeats every 255 clocks.
- R6: In self-test mode, the next state is the R5 shift result XORed bit by bit with par_in.
- R7: In self-test mode, when the register and par_in are both all zero, the next state is the seed value 8'h01 instead of zero. Self-test mode with par_in all zero therefore never produces an all-zero state.
- R8: par_out always equals the register contents, and scan_out always equals the register's most significant bit, in every mode.
- R9: rst is synchronous and active-high. While it is high, a rising clock edge clears the register whatever the mode pins hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| mode_c0 | input | 1 | Upper bit of the mode code |
| mode_c1 | input | 1 | Lower bit of the mode code |
| par_in | input | WIDTH | Parallel data, or the response being compacted |
| scan_in | input | 1 | Serial input to bit 0 in scan mode |
| par_out | output | WIDTH | Current register contents |
| scan_out | output | 1 | Register most significant bit |

## Verification
Some behaviours are checked by assertions on every clock. These are the single-step transition of scan, clear and normal load, and the clear under reset. They also cover the fact that self-test with zero inputs never yields an all-zero state, both from the zero state and from nonzero states. Other behaviours can only be shown by the bench's scenarios: the exact self-test sequence and its 255-step period, the signatures built up from several changing inputs, and a full byte scanned in and then out again bit by bit.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    // Mode code is {c0, c1}
    typedef enum logic [1:0] {
        MODE_SCAN     = 2'b00,
        MODE_CLEAR    = 2'b01,
        MODE_SELFTEST = 2'b10,
        MODE_NORMAL   = 2'b11
    } bilbo_mode_e;

    localparam int DEFAULT_WIDTH = 8;
    localparam logic [DEFAULT_WIDTH-1:0] DEFAULT_TAPS = 8'hB8;
    localparam logic [DEFAULT_WIDTH-1:0] DEFAULT_SEED = 8'h01;

    function automatic bilbo_mode_e decode_mode(input logic c0, input logic c1);
        return bilbo_mode_e'({c0, c1});
    endfunction

endpackage

// File: rtl/bilbo_mode_dec.sv
module bilbo_mode_dec
    import bilbo_pkg::*;
(
    input  logic        c0,
    input  logic        c1,
    output bilbo_mode_e mode
);
    always_comb mode = decode_mode(c0, c1);
endmodule

// File: rtl/bilbo_misr_step.sv
module bilbo_misr_step #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8,
    parameter logic [WIDTH-1:0] SEED  = 8'h01,
    parameter bit               GUARD = 1'b1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    logic             fb;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] raw;

    always_comb begin
        fb      = ^(cur & TAPS);
        shifted = {cur[WIDTH-2:0], fb};
        raw     = shifted ^ din;
    end

    generate
        if (GUARD) begin : g_guard
            always_comb begin
                if (cur == '0 && din == '0) nxt = SEED;
                else                        nxt = raw;
            end
        end else begin : g_noguard
            always_comb nxt = raw;
        end
    endgenerate

    // R7
    always_comb begin
        if (GUARD && din == '0) begin
            no_zero_step_chk: assert (nxt != '0)
                else $error("self-test step with zero input reached zero");
        end
    end
endmodule

// File: rtl/bilbo_core.sv
module bilbo_core
    import bilbo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bilbo_mode_e      mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] st_next,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (mode)
                MODE_SCAN:     q <= {q[WIDTH-2:0], scan_in};
                MODE_CLEAR:    q <= '0;
                MODE_SELFTEST: q <= st_next;
                MODE_NORMAL:   q <= par_in;
                default:       q <= q;
            endcase
        end
    end

    // R9
    rst_clear_chk: assert property (@(posedge clk) rst |=> q == '0)
        else $error("reset did not clear register");
    // R2
    scan_shift_chk: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_SCAN |=> q == {$past(q[WIDTH-2:0]), $past(scan_in)})
        else $error("scan shift wrong");
    // R3
    clear_mode_chk: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_CLEAR |=> q == '0)
        else $error("clear mode left bits set");
    // R4
    normal_load_chk: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_NORMAL |=> q == $past(par_in))
        else $error("normal load wrong");
    // R7
    st_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SELFTEST && par_in == '0) |=> q != '0)
        else $error("self-test locked at zero");
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int               WIDTH = DEFAULT_WIDTH,
    parameter logic [WIDTH-1:0] TAPS  = DEFAULT_TAPS,
    parameter logic [WIDTH-1:0] SEED  = DEFAULT_SEED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_c0,
    input  logic             mode_c1,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);
    localparam int MSB = WIDTH - 1;

    bilbo_mode_e      mode;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] st_next;

    bilbo_mode_dec u_dec (
        .c0   (mode_c0),
        .c1   (mode_c1),
        .mode (mode)
    );

    bilbo_misr_step #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS),
        .SEED  (SEED),
        .GUARD (1'b1)
    ) u_step (
        .cur (q),
        .din (par_in),
        .nxt (st_next)
    );

    bilbo_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .par_in  (par_in),
        .scan_in (scan_in),
        .st_next (st_next),
        .q       (q)
    );

    assign par_out  = q;
    assign scan_out = q[MSB];
endmodule

// File: tb/bilbo_reg_tb.sv
module bilbo_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       c0 = 1'b1, c1 = 1'b1;
    logic [7:0] pin = 8'h00;
    logic       sin = 1'b0;
    logic [7:0] pout;
    logic       sout;
    int total = 0;
    int bad = 0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    bilbo_reg u_dut (
        .clk(clk), .rst(rst), .mode_c0(c0), .mode_c1(c1),
        .par_in(pin), .scan_in(sin), .par_out(pout), .scan_out(sout)
    );

    // entry: {mode[1:0], scan_in, par_in[7:0]}
    localparam logic [10:0] TBL [0:15] = '{
        {2'b11, 1'b0, 8'h5A}, {2'b00, 1'b1, 8'hFF}, {2'b00, 1'b0, 8'h00},
        {2'b00, 1'b1, 8'h33}, {2'b01, 1'b1, 8'hFF}, {2'b10, 1'b0, 8'h00},
        {2'b10, 1'b0, 8'h00}, {2'b10, 1'b0, 8'h00}, {2'b10, 1'b0, 8'h3C},
        {2'b10, 1'b0, 8'hA5}, {2'b10, 1'b0, 8'h01}, {2'b11, 1'b0, 8'hC3},
        {2'b10, 1'b0, 8'hFF}, {2'b10, 1'b1, 8'h80}, {2'b00, 1'b1, 8'h00},
        {2'b11, 1'b0, 8'h00}
    };

    // expected next state from R1..R7
    function automatic logic [7:0] ref_next(logic [7:0] q, logic [1:0] m,
                                            logic si, logic [7:0] pi);
        logic [7:0] n;
        case (m)
            2'b00: n = {q[6:0], si};
            2'b01: n = 8'h00;
            2'b10: begin
                n = {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]} ^ pi;
                if (n == 8'h00 && pi == 8'h00) n = 8'h01;
            end
            default: n = pi;
        endcase
        return n;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic [1:0] m, logic si, logic [7:0] pi);
        {c0, c1} = m; sin = si; pin = pi;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R9 reset state", pout, 8'h00);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < 16; i++) begin
            step(TBL[i][10:9], TBL[i][8], TBL[i][7:0]);
            model = ref_next(model, TBL[i][10:9], TBL[i][8], TBL[i][7:0]);
            check($sformatf("R1-mode vec%0d par_out (R8)", i), pout, model);
            check($sformatf("R8 vec%0d scan_out", i), {7'b0, sout}, {7'b0, model[7]});
        end

        // R7: lock-up from zero, then R5 period of 255
        step(2'b01, 1'b0, 8'h00);
        check("R3 clear", pout, 8'h00);
        step(2'b10, 1'b0, 8'h00);
        check("R7 seed from zero", pout, 8'h01);
        begin
            int period = 0;
            int zeros  = 0;
            for (int k = 1; k <= 300; k++) begin
                step(2'b10, 1'b0, 8'h00);
                if (pout == 8'h00) zeros++;
                if (pout == 8'h01 && period == 0) period = k;
            end
            check("R5 period", period[7:0], 8'd255);
            check("R7 never zero", zeros[7:0], 8'd0);
        end

        // R6: signature of a known response stream, computed from the rule
        step(2'b01, 1'b0, 8'h00);
        model = 8'h00;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] d;
            d = 8'h11 * k[7:0] + 8'h07;
            step(2'b10, 1'b0, d);
            model = ref_next(model, 2'b10, 1'b0, d);
        end
        check("R6 signature", pout, model);

        // R2: scan a byte in, then out bit by bit
        begin
            logic [7:0] pat = 8'hA6;
            for (int b = 7; b >= 0; b--) step(2'b00, pat[b], 8'h00);
            check("R2 scan in", pout, pat);
            for (int b = 7; b >= 0; b--) begin
                check("R2 scan out bit", {7'b0, sout}, {7'b0, pat[b]});
                step(2'b00, 1'b0, 8'h00);
            end
            check("R2 flushed", pout, 8'h00);
        end

        // R4 then R9: reset wins over normal load and over self-test
        step(2'b11, 1'b0, 8'hFF);
        check("R4 load", pout, 8'hFF);
        rst = 1'b1;
        step(2'b11, 1'b1, 8'hFF);
        check("R9 reset over normal", pout, 8'h00);
        rst = 1'b0;
        step(2'b11, 1'b0, 8'h81);
        rst = 1'b1;
        step(2'b10, 1'b1, 8'h00);
        check("R9 reset over self-test", pout, 8'h00);
        rst = 1'b0;

        // R3: clear ignores par_in and scan_in
        step(2'b11, 1'b0, 8'h7E);
        step(2'b01, 1'b1, 8'hFF);
        check("R3 clear ignores inputs", pout, 8'h00);

        summary();
    end
endmodule